// File: doc/BRIEF.md
# Receive FIFO with Fill Trigger and Idle Timeout

This block buffers received bytes for an asynchronous serial port. A receiver front end delivers each byte with a one-cycle valid strobe; the block stores it in a sixteen-entry circular buffer, provided reception is enabled. Software drains the buffer one byte per read strobe and can see the current occupancy at all times.

A receive-full flag, with an optional interrupt, tells software that data is waiting. The flag is set when the fill level reaches a programmable trigger. It is also set when fewer bytes than the trigger have arrived and the line then stays quiet for fifteen elementary time units. A separate one-cycle tick, supplied from outside, marks each time unit. Reads clear the flag once the level drops below the trigger. A FIFO-control write selects the trigger and can flush the buffer.

Top module: `rxq_trig_fifo`

## Requirements
- R1: The buffer holds up to 16 bytes and returns them in arrival order. `level` always equals the number of stored bytes (0 to 16).
- R2: An incoming byte is dropped when 16 bytes are already stored, or when the receive-enable bit (control bit 4) is clear.
- R3: FIFO-control bits [7:6] select the trigger: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14. After reset the trigger is 1. A new trigger applies from the cycle after the write.
- R4: A FIFO-control write with bit 1 set empties the buffer, clears `rx_full` and `rx_irq`, and cancels any pending timeout. Any byte or read in the same cycle is ignored.
- R5: When a stored byte brings the level to the trigger or above, `rx_full` is set. `rx_irq` is also set if the receive-interrupt enable (control bit 6) is set. Any pending timeout is cancelled.
- R6: A stored byte that leaves the level below the trigger restarts an idle timer. On the 15th `etu_tick` after that byte, with no further byte stored, `rx_full` is set, together with `rx_irq` if control bit 6 is set.
- R7: A read strobe with a non-empty buffer removes the oldest byte. If the resulting level is below the trigger and no byte set the flag in the same cycle, `rx_full` and `rx_irq` clear.
- R8: A read strobe with an empty buffer changes nothing, and `rd_data` reads zero while the buffer is empty.
- R9: A byte stored and a byte read in the same cycle leave `level` unchanged and keep the order of the data.
- R10: A control write with bit 6 clear drops `rx_irq` at that clock edge. This takes priority over any event that would set it.
- R11: After reset: `level` 0, `rx_full` 0, `rx_irq` 0, reception disabled, interrupt disabled, trigger 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_vld | input | 1 | Received byte strobe from the front end |
| byte_in | input | 8 | Received byte |
| etu_tick | input | 1 | One-cycle pulse per elementary time unit |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control data: bit 4 receive enable, bit 6 receive interrupt enable |
| fcr_wr | input | 1 | FIFO-control write strobe |
| fcr_wdata | input | 8 | FIFO-control data: bits [7:6] trigger, bit 1 flush |
| rd_pop | input | 1 | Data read strobe; removes the oldest byte |
| rd_data | output | 8 | Oldest stored byte, zero when empty |
| level | output | 5 | Number of stored bytes |
| rx_full | output | 1 | Receive-full flag |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Every input takes effect at the next rising edge. `level` and `rd_data` show the new contents right after that edge. `rx_full` and `rx_irq` also update at that edge, including on the edge where the 15th tick is seen. A new trigger value counts only from the following cycle. The bench drives its inputs between edges, advances a queue-based model on each rising edge using the inputs present at that edge, and compares all four outputs one time step later. No result is left to a later cycle.

// File: rtl/rxq_pkg.sv
// Package: shared sizes and the trigger decode for the receive FIFO.
// Assumes byte-wide data and a two-bit trigger select field.
package rxq_pkg;
    localparam int RXQ_DEPTH   = 16;
    localparam int RXQ_DW      = 8;
    localparam int RXQ_IDLE    = 15;
    localparam int RXQ_CW      = $clog2(RXQ_DEPTH + 1);

    // Map the two-bit select onto a fill threshold.
    function automatic logic [RXQ_CW-1:0] trig_decode(input logic [1:0] sel);
        case (sel)
            2'd0:    trig_decode = RXQ_CW'(1);
            2'd1:    trig_decode = RXQ_CW'(4);
            2'd2:    trig_decode = RXQ_CW'(8);
            default: trig_decode = RXQ_CW'(14);
        endcase
    endfunction
endpackage

// File: rtl/rxq_store.sv
// Module: circular byte store with write index, read index and occupancy.
// Assumes the caller only pushes when not full and only pops when not
// empty; flush overrides both.
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    input  logic          flush,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_idx, rd_idx;

    // Wrap an index at the end of the buffer.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] i);
        bump = (i == AW'(DEPTH - 1)) ? '0 : i + AW'(1);
    endfunction

    // Write the incoming byte into the slot at the write index.
    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_idx] <= din;
    end

    // Advance indices and occupancy; flush zeroes all three.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
        end else begin
            if (push) wr_idx <= bump(wr_idx);
            if (pop)  rd_idx <= bump(rd_idx);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Present the oldest byte, zero while empty.
    always_comb dout = (count == '0) ? '0 : mem[rd_idx];

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R9
    push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !flush) |=> $stable(count));
    // R4
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && wr_idx == rd_idx));
    // R8
    idle_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop && !flush) |=> ($stable(rd_idx) && $stable(wr_idx)));
endmodule

// File: rtl/rxq_idle_timer.sv
// Module: idle timer counting elementary time units after a sub-trigger byte.
// Assumes restart and cancel are mutually exclusive; cancel wins if not.
module rxq_idle_timer #(
    parameter int IDLE = 15,
    localparam int TW  = $clog2(IDLE + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic cancel,
    input  logic tick,
    output logic fire
);
    logic          armed;
    logic [TW-1:0] ticks;

    // Fire on the tick that completes the idle window.
    always_comb fire = armed && tick && (ticks == TW'(IDLE - 1)) && !restart && !cancel;

    // Arm on restart, count ticks while armed, disarm on fire or cancel.
    always_ff @(posedge clk) begin
        if (!rst_n || cancel) begin
            armed <= 1'b0;
            ticks <= '0;
        end else if (restart) begin
            armed <= 1'b1;
            ticks <= '0;
        end else if (fire) begin
            armed <= 1'b0;
            ticks <= '0;
        end else if (armed && tick) begin
            ticks <= ticks + TW'(1);
        end
    end

    // R6
    tmo_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ticks < TW'(IDLE));
    // R6
    tmo_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !armed);
endmodule

// File: rtl/rxq_trig_fifo.sv
// Module: receive FIFO top; holds the enable, interrupt-enable and trigger
// settings and drives the receive-full flag and interrupt.
// Assumes etu_tick is a single-cycle pulse and rd_pop one strobe per read.
module rxq_trig_fifo
    import rxq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_vld,
    input  logic [7:0]  byte_in,
    input  logic        etu_tick,
    input  logic        ctl_wr,
    input  logic [7:0]  ctl_wdata,
    input  logic        fcr_wr,
    input  logic [7:0]  fcr_wdata,
    input  logic        rd_pop,
    output logic [7:0]  rd_data,
    output logic [4:0]  level,
    output logic        rx_full,
    output logic        rx_irq
);
    localparam int CW = RXQ_CW;

    logic          rx_en, rie;
    logic [CW-1:0] trig, cnt, cnt_nxt;
    logic          flush, push_ok, pop_ok, hit, tmo_fire, set_ev, clr_ev;

    // Qualify the strobes and work out the post-update level.
    always_comb begin
        flush   = fcr_wr && fcr_wdata[1];
        push_ok = byte_vld && rx_en && (cnt != CW'(RXQ_DEPTH)) && !flush;
        pop_ok  = rd_pop && (cnt != '0) && !flush;
        cnt_nxt = cnt + CW'(push_ok) - CW'(pop_ok);
        hit     = push_ok && (cnt_nxt >= trig);
        set_ev  = hit || tmo_fire;
        clr_ev  = pop_ok && (cnt_nxt < trig) && !set_ev;
    end

    rxq_store #(.DEPTH(RXQ_DEPTH), .DW(RXQ_DW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_ok),
        .din   (byte_in),
        .pop   (pop_ok),
        .flush (flush),
        .dout  (rd_data),
        .count (cnt)
    );

    rxq_idle_timer #(.IDLE(RXQ_IDLE)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (push_ok && !hit),
        .cancel  (hit || flush),
        .tick    (etu_tick),
        .fire    (tmo_fire)
    );

    // Hold the control bits and the decoded trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en <= 1'b0;
            rie   <= 1'b0;
            trig  <= CW'(1);
        end else begin
            if (ctl_wr) begin
                rx_en <= ctl_wdata[4];
                rie   <= ctl_wdata[6];
            end
            if (fcr_wr) trig <= trig_decode(fcr_wdata[7:6]);
        end
    end

    // Update the receive-full flag and the interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rx_full <= 1'b0;
            rx_irq  <= 1'b0;
        end else begin
            if (set_ev)      rx_full <= 1'b1;
            else if (clr_ev) rx_full <= 1'b0;
            if (ctl_wr && !ctl_wdata[6]) rx_irq <= 1'b0;
            else if (set_ev && rie)      rx_irq <= 1'b1;
            else if (clr_ev)             rx_irq <= 1'b0;
        end
    end

    always_comb level = cnt;

    // R5
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_full);
    // R6
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_full) && !$past(push_ok)) |-> $past(tmo_fire));
    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_wdata[6]) |=> !rx_irq);
    // R2
    drop_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !rd_pop && !fcr_wr) |=> $stable(level));
    // R8
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == 5'd0) |-> (rd_data == 8'd0));
endmodule

// File: tb/rxq_trig_fifo_bench.sv
module rxq_trig_fifo_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0, etu_tick = 1'b0, ctl_wr = 1'b0, fcr_wr = 1'b0, rd_pop = 1'b0;
    logic [7:0] byte_in = '0, ctl_wdata = '0, fcr_wdata = '0;
    logic [7:0] rd_data;
    logic [4:0] level;
    logic       rx_full, rx_irq;

    always #2.5 clk = ~clk;

    rxq_trig_fifo u_rxq_trig_fifo (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
        .etu_tick(etu_tick), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata), .rd_pop(rd_pop),
        .rd_data(rd_data), .level(level), .rx_full(rx_full), .rx_irq(rx_irq)
    );

    int checks = 0, errors = 0;
    string cur_req = "R11";
    bit done = 1'b0;

    // Behavioural model state.
    byte unsigned q[$];
    int  m_trig = 1, m_ticks = 0;
    bit  m_en = 0, m_rie = 0, m_full = 0, m_irq = 0, m_armed = 0;

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("level", level, q.size());
        chk("rd_data", rd_data, (q.size() == 0) ? 0 : q[0]);
        chk("rx_full", rx_full, m_full);
        chk("rx_irq", rx_irq, m_irq);
    endtask

    // Advance the model by one edge using the inputs being driven.
    task automatic model_edge();
        int n = q.size();
        bit fl = fcr_wr && fcr_wdata[1];
        bit dpush, dpop, fire, setv;
        if (fl) begin
            q.delete(); m_full = 0; m_irq = 0; m_armed = 0; m_ticks = 0;
        end else begin
            dpush = byte_vld && m_en && n < 16;
            dpop  = rd_pop && n > 0;
            if (dpop) void'(q.pop_front());
            if (dpush) q.push_back(byte_in);
            fire = 0;
            if (dpush) begin
                if (q.size() >= m_trig) m_armed = 0;
                else begin m_armed = 1; m_ticks = 0; end
            end else if (m_armed && etu_tick) begin
                m_ticks++;
                if (m_ticks == 15) begin fire = 1; m_armed = 0; m_ticks = 0; end
            end
            setv = (dpush && q.size() >= m_trig) || fire;
            if (setv) begin
                m_full = 1;
                if (m_rie) m_irq = 1;
            end else if (dpop && q.size() < m_trig) begin
                m_full = 0; m_irq = 0;
            end
            if (ctl_wr && !ctl_wdata[6]) m_irq = 0;
        end
        if (ctl_wr) begin m_en = ctl_wdata[4]; m_rie = ctl_wdata[6]; end
        if (fcr_wr) case (fcr_wdata[7:6])
            2'd0: m_trig = 1;
            2'd1: m_trig = 4;
            2'd2: m_trig = 8;
            default: m_trig = 14;
        endcase
    endtask

    // One clock: inputs already driven; update model, compare, clear strobes.
    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        compare_all();
        byte_vld = 0; etu_tick = 0; ctl_wr = 0; fcr_wr = 0; rd_pop = 0;
    endtask

    task automatic put(input byte unsigned b);
        byte_vld = 1; byte_in = b; step();
    endtask
    task automatic get(); rd_pop = 1; step(); endtask
    task automatic tick(); etu_tick = 1; step(); endtask
    task automatic ctl(input logic [7:0] d); ctl_wr = 1; ctl_wdata = d; step(); endtask
    task automatic fcr(input logic [7:0] d); fcr_wr = 1; fcr_wdata = d; step(); endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5ns * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        // R11: reset state
        cur_req = "R11";
        compare_all();
        put(8'h11);                         // rx disabled: dropped (R11 and R2)
        cur_req = "R5";
        ctl(8'h50);                         // enable rx and interrupt
        put(8'hA1);                         // trigger 1 reached
        put(8'hA2); put(8'hA3);
        cur_req = "R7";
        get(); get(); get();                // flag clears on last pop
        cur_req = "R8";
        get(); get();                       // pop on empty
        cur_req = "R3";
        fcr(8'h40);                         // trigger 4
        put(8'h01); put(8'h02); put(8'h03);
        cur_req = "R6";
        for (int i = 0; i < 16; i++) tick();  // timeout on the 15th
        get(); get(); get();
        put(8'h04);
        for (int i = 0; i < 7; i++) tick();
        put(8'h05);                         // restart
        for (int i = 0; i < 14; i++) tick();
        put(8'h06); put(8'h07);             // reaches 4: cancels the timer
        for (int i = 0; i < 20; i++) tick();
        cur_req = "R4";
        fcr(8'h82);                         // flush, trigger 8
        for (int i = 0; i < 20; i++) tick();
        cur_req = "R3";
        for (int i = 0; i < 8; i++) put(8'(8'h20 + i));
        fcr(8'hC0);                         // trigger 14
        for (int i = 0; i < 6; i++) put(8'(8'h30 + i));
        cur_req = "R2";
        for (int i = 0; i < 4; i++) put(8'(8'h40 + i));   // full: dropped
        cur_req = "R1";
        chk("full level", level, 16);
        cur_req = "R9";
        byte_vld = 1; byte_in = 8'h77; rd_pop = 1; step();
        get();
        byte_vld = 1; byte_in = 8'h78; rd_pop = 1; step();
        cur_req = "R10";
        ctl(8'h10);                         // mask irq
        ctl(8'h50);
        put(8'h79);                         // flag set, irq again
        byte_vld = 1; byte_in = 8'h7A; ctl_wr = 1; ctl_wdata = 8'h10; step();
        cur_req = "R4";
        byte_vld = 1; rd_pop = 1; fcr_wr = 1; fcr_wdata = 8'h02; step();
        cur_req = "R2";
        ctl(8'h40);
        put(8'h55);
        cur_req = "R1";
        ctl(8'h50);
        for (int i = 0; i < 3000; i++) begin
            byte_vld = ($urandom_range(0, 2) == 0); byte_in = 8'($urandom);
            rd_pop   = ($urandom_range(0, 3) == 0);
            etu_tick = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 60) == 0) begin
                fcr_wr = 1; fcr_wdata = {2'($urandom), 4'd0, ($urandom_range(0, 4) == 0), 1'b0};
            end
            if ($urandom_range(0, 80) == 0) begin
                ctl_wr = 1; ctl_wdata = {1'b0, 1'($urandom), 1'b0, 1'($urandom_range(0, 5) != 0), 4'd0};
            end
            step();
        end
        finish_run();
    end
endmodule